// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks the two ALU operands for the execute stage of a five-stage pipeline. Each operand names a source register, held in the decode-to-execute register. The block compares that register number with the destination of the instruction now in the memory stage and with the destination of the instruction now in writeback. When a later stage is about to write the register the operand needs, the block steers that stage's value to the ALU in place of the stale register-file read.

The memory-stage result is the younger of the two, so it wins when both stages target the same register. The writeback value is the final value that will be written back, so it may be load data or an ALU result. Register zero is hard-wired and is never bypassed. The selector is purely combinational. For each operand it returns a two-bit source code and the chosen data word. The pipeline control around it handles stalls for load-use cases and the register-file write-through.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage write enable is 1, its destination is nonzero and it equals an operand's source register, that operand's select is 2'b10 and its value is the memory-stage result.
- R2: When the memory-stage condition of R1 is false for an operand, and the writeback-stage write enable is 1, its destination is nonzero and it equals that source register, the select is 2'b01 and the value is the writeback value.
- R3: When both stages meet their match condition for the same operand, the memory stage is chosen (select 2'b10), so the most recent producer is delivered.
- R4: A source register of zero is never bypassed: its select is 2'b00 and its value is the register-file read, whatever the stage destinations are.
- R5: A stage whose write enable is 0 never supplies an operand, even when its destination matches.
- R6: When no stage matches, the select is 2'b00 and the operand equals the register-file read value unchanged.
- R7: Operand A and operand B are resolved independently. Each follows only its own source register and register-file value.
- R8: The outputs depend combinationally on the present inputs and follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Source register number of operand A |
| ex_src_b | input | 5 | Source register number of operand B |
| rf_val_a | input | 32 | Register-file read value for operand A |
| rf_val_b | input | 32 | Register-file read value for operand B |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | 5 | Writeback-stage destination register |
| wb_value | input | 32 | Final writeback value (load data or ALU result) |
| sel_a | output | 2 | Source code for A: 00 register file, 01 writeback, 10 memory stage |
| sel_b | output | 2 | Source code for B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The table drives single-stage matches on each operand to separate the memory-stage path from the writeback path. Double matches on one register show that the priority favours the younger producer. Zero-register cases with both write enables high show that the hard-wired register is excluded rather than matched. Disabled-enable cases with matching destinations show that the enable is part of the match. Mixed cases, where A and B hit different stages, expose any crosstalk between the two operand paths. A long random sweep over a narrow register range hits every mix of matches and enables and compares against a priority model. A mid-cycle data change confirms that no register sits on the path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Source code presented on sel_a / sel_b
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_src_e;

endpackage

// File: rtl/fwd_hit.sv
// Match detector for one producing stage against one consumer register.
module fwd_hit #(
    parameter int REG_W = 5
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    output logic             hit
);

    always_comb begin
        hit = wr_en && (dst != '0) && (dst == src);
    end

endmodule

// File: rtl/fwd_pick.sv
// Priority resolution and data steering for one operand.
module fwd_pick
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              hit_mem,
    input  logic              hit_wb,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output fwd_src_e          sel,
    output logic [DATA_W-1:0] val
);

    // younger producer first
    always_comb begin
        if (hit_mem) begin
            sel = FWD_MEM;
        end else if (hit_wb) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

    always_comb begin
        unique case (sel)
            FWD_MEM: val = mem_val;
            FWD_WB:  val = wb_val;
            default: val = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic [REG_W-1:0]  ex_src_a,
    input  logic [REG_W-1:0]  ex_src_b,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic              mem_wr_en,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic [DATA_W-1:0] mem_result,
    input  logic              wb_wr_en,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPS = 2;

    logic [REG_W-1:0]  src_arr [NUM_OPS];
    logic [DATA_W-1:0] rf_arr  [NUM_OPS];
    logic [DATA_W-1:0] val_arr [NUM_OPS];
    fwd_src_e          sel_arr [NUM_OPS];

    assign src_arr[0] = ex_src_a;
    assign src_arr[1] = ex_src_b;
    assign rf_arr[0]  = rf_val_a;
    assign rf_arr[1]  = rf_val_b;

    // identical, independent path per operand
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic hit_mem;
        logic hit_wb;

        fwd_hit #(.REG_W(REG_W)) u_hit_mem (
            .wr_en (mem_wr_en),
            .dst   (mem_dst),
            .src   (src_arr[g]),
            .hit   (hit_mem)
        );

        fwd_hit #(.REG_W(REG_W)) u_hit_wb (
            .wr_en (wb_wr_en),
            .dst   (wb_dst),
            .src   (src_arr[g]),
            .hit   (hit_wb)
        );

        fwd_pick #(.DATA_W(DATA_W)) u_pick (
            .hit_mem (hit_mem),
            .hit_wb  (hit_wb),
            .rf_val  (rf_arr[g]),
            .mem_val (mem_result),
            .wb_val  (wb_value),
            .sel     (sel_arr[g]),
            .val     (val_arr[g])
        );
    end

    assign sel_a  = sel_arr[0];
    assign sel_b  = sel_arr[1];
    assign opnd_a = val_arr[0];
    assign opnd_b = val_arr[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input logic [REG_W-1:0]  ex_src_a,
    input logic [REG_W-1:0]  ex_src_b,
    input logic [DATA_W-1:0] rf_val_a,
    input logic [DATA_W-1:0] rf_val_b,
    input logic              mem_wr_en,
    input logic [REG_W-1:0]  mem_dst,
    input logic [DATA_W-1:0] mem_result,
    input logic              wb_wr_en,
    input logic [REG_W-1:0]  wb_dst,
    input logic [DATA_W-1:0] wb_value,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    always_comb begin
        // R1 / R3: memory stage wins whenever it matches
        if (mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a)
            p_mem_pick_a_r1: assert (sel_a == 2'b10 && opnd_a == mem_result);
        if (mem_wr_en && mem_dst != '0 && mem_dst == ex_src_b)
            p_mem_pick_b_r3: assert (sel_b == 2'b10 && opnd_b == mem_result);
        // R2: writeback path
        if (sel_a == 2'b01)
            p_wb_pick_a_r2: assert (wb_wr_en && wb_dst == ex_src_a && opnd_a == wb_value);
        if (sel_b == 2'b01)
            p_wb_pick_b_r2: assert (wb_wr_en && wb_dst == ex_src_b && opnd_b == wb_value);
        // R4: register zero never bypassed
        if (ex_src_a == '0)
            p_zero_a_r4: assert (sel_a == 2'b00);
        if (ex_src_b == '0)
            p_zero_b_r4: assert (sel_b == 2'b00);
        // R5: no enable, no bypass
        if (!mem_wr_en && !wb_wr_en)
            p_no_we_r5: assert (sel_a == 2'b00 && sel_b == 2'b00);
        // R6: pass-through value
        if (sel_a == 2'b00)
            p_pass_a_r6: assert (opnd_a == rf_val_a);
        if (sel_b == 2'b00)
            p_pass_b_r6: assert (opnd_b == rf_val_b);
    end

endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;

    localparam int DW = 32;
    localparam int RW = 5;
    localparam logic [DW-1:0] RF_A = 32'hA0A0_0001;
    localparam logic [DW-1:0] RF_B = 32'hB0B0_0002;
    localparam logic [DW-1:0] MEMV = 32'h1111_0003;
    localparam logic [DW-1:0] WBV  = 32'h2222_0004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [RW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic [DW-1:0] rf_val_a, rf_val_b, mem_result, wb_value;
    logic          mem_wr_en, wb_wr_en;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    fwd_unit #(.DATA_W(DW), .REG_W(RW)) u_dut (.*);

    // {src_a, src_b, mem_we, mem_dst, wb_we, wb_dst, exp_sel_a, exp_sel_b}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1 on A
        {5'd1,  5'd7,  1'b1, 5'd7,  1'b0, 5'd0,  2'b00, 2'b10}, // R1 on B
        {5'd5,  5'd6,  1'b0, 5'd0,  1'b1, 5'd5,  2'b01, 2'b00}, // R2 on A
        {5'd2,  5'd9,  1'b1, 5'd4,  1'b1, 5'd9,  2'b00, 2'b01}, // R2 on B
        {5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 5'd8,  2'b10, 2'b10}, // R3 both stages
        {5'd3,  5'd5,  1'b1, 5'd3,  1'b1, 5'd5,  2'b10, 2'b01}, // R3 / R7 mixed
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R4 zero
        {5'd0,  5'd2,  1'b1, 5'd0,  1'b1, 5'd2,  2'b00, 2'b01}, // R4 zero on A
        {5'd6,  5'd6,  1'b0, 5'd6,  1'b0, 5'd6,  2'b00, 2'b00}, // R5 enables low
        {5'd4,  5'd4,  1'b0, 5'd4,  1'b1, 5'd4,  2'b01, 2'b01}, // R5 mem disabled
        {5'd10, 5'd11, 1'b1, 5'd12, 1'b1, 5'd13, 2'b00, 2'b00}, // R6 no match
        {5'd31, 5'd30, 1'b1, 5'd30, 1'b1, 5'd31, 2'b01, 2'b10}  // R7 crossed
    };

    function automatic logic [1:0] ref_sel(input logic [RW-1:0] s);
        if (mem_wr_en && mem_dst != 0 && mem_dst == s) return 2'b10;
        if (wb_wr_en && wb_dst != 0 && wb_dst == s)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] ref_val(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b10:   return mem_result;
            2'b01:   return wb_value;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        logic [1:0] ea, eb;
        ea = ref_sel(ex_src_a);
        eb = ref_sel(ex_src_b);
        check(req, "sel_a",  {30'd0, sel_a}, {30'd0, ea});
        check(req, "sel_b",  {30'd0, sel_b}, {30'd0, eb});
        check(req, "opnd_a", opnd_a, ref_val(ea, rf_val_a));
        check(req, "opnd_b", opnd_b, ref_val(eb, rf_val_b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_wr_en = 1'b0; wb_wr_en = 1'b0;
        rf_val_a = RF_A; rf_val_b = RF_B; mem_result = MEMV; wb_value = WBV;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle state: R6 pass-through
        @(negedge clk); #1;
        check("R6", "idle sel_a",  {30'd0, sel_a}, 32'd0);
        check("R6", "idle opnd_b", opnd_b, RF_B);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ex_src_a, ex_src_b, mem_wr_en, mem_dst, wb_wr_en, wb_dst} = VEC[i][25:4];
            #1;
            check($sformatf("R%0d table %0d", (i / 2) + 1, i), "sel_a",
                  {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
            check($sformatf("R%0d table %0d", (i / 2) + 1, i), "sel_b",
                  {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
            check_both("R7 table");
        end

        // R3: three consecutive writers to r1; consumer sees the newest
        @(negedge clk);
        ex_src_a = 5'd1; ex_src_b = 5'd1;
        mem_wr_en = 1'b1; mem_dst = 5'd1; mem_result = 32'h0000_0030;
        wb_wr_en  = 1'b1; wb_dst  = 5'd1; wb_value   = 32'h0000_0020;
        rf_val_a  = 32'h0000_0010; rf_val_b = 32'h0000_0010;
        #1;
        check("R3", "chain opnd_a", opnd_a, 32'h0000_0030);

        // R8: data change mid-cycle, no edge
        #1;
        mem_result = 32'hDEAD_BEEF;
        #1;
        check("R8", "opnd_a follows", opnd_a, 32'hDEAD_BEEF);

        // R7: changing B's source leaves A unchanged
        ex_src_b = 5'd9; rf_val_b = 32'h5555_5555;
        #1;
        check("R7", "opnd_a held", opnd_a, 32'hDEAD_BEEF);
        check("R7", "opnd_b own",  opnd_b, 32'h5555_5555);

        // random sweep over narrow register range
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            ex_src_a   = RW'($urandom_range(0, 3));
            ex_src_b   = RW'($urandom_range(0, 3));
            mem_dst    = RW'($urandom_range(0, 3));
            wb_dst     = RW'($urandom_range(0, 3));
            mem_wr_en  = 1'($urandom);
            wb_wr_en   = 1'($urandom);
            rf_val_a   = $urandom;
            rf_val_b   = $urandom;
            mem_result = $urandom;
            wb_value   = $urandom;
            #1;
            check_both("R1 R2 R3 R4 R5 random");
        end

        finish_run();
    end

endmodule